// File: doc/BRIEF.md
# SD Command Line Sequencer

This block drives the bidirectional command line of an SD/MMC card for a single command at a time. A 32-bit argument is loaded first. A second write then supplies a 6-bit command index, a 2-bit response mode, a stop marker and a start bit. The block builds a 48-bit frame with its CRC7 and shifts it out MSB first. Each bit lasts one card-clock period, marked by the `card_tick` enable. If the mode asks for a reply, the block then listens on the line and captures a short (48-bit) or long (136-bit) response. It checks the CRC where the mode requires it and stores the payload in four 32-bit response words.

Each command ends by raising exactly one of four sticky flags: frame sent, response received, response CRC failure or response timeout. A flag stays set until a clear write names it in the mask. A command marked as a stop emits a one-cycle pulse when its frame finishes, so that a data engine elsewhere can abort its transfer. The host polls `busy` to learn when the block can take the next command.

Top module: `sdc_cmd_path`

## Requirements
- R1: An accepted command produces exactly 48 bits on `line_out`, MSB first, while `line_oe` is high. The bits are: 0, 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero initial value) over the preceding 40 bits, and a final 1. When `line_oe` is low, `line_out` is 1.
- R2: A command starts only on a cycle with `cmd_wr` and `cmd_start` both high while the block is idle. A write with `cmd_start` low has no effect.
- R3: `busy` is high from the cycle after an accepted write until the command finishes. Command writes made while `busy` is high are ignored.
- R4: Response mode 0 (no response) sets flag bit 0 (sent) when the end bit has been shifted out. It then returns to idle without listening.
- R5: Mode 1 is short with CRC check, mode 2 is short without check, and mode 3 is long. After the end bit, the block samples `line_in` once per tick. A 0 on any of the first 64 samples is taken as the response start bit. Otherwise flag bit 3 (timeout) is set on the 64th sample.
- R6: A short response carries 48 bits and a long one 136 bits, the start bit included. Modes 1 and 3 compare the received CRC with one computed locally; a mismatch sets flag bit 2 (CRC fail) and a match sets flag bit 1 (response). The local CRC covers bits 46..8 for a short response and bits 127..8 for a long one. Mode 2 always sets flag bit 1.
- R7: A short response writes bits 39..8 into word 1, which is `resp_data[127:96]`, and leaves words 2 to 4 unchanged. A long response writes its last 128 bits into words 1 to 4, first received first. The words are written whether or not the CRC matched.
- R8: A command written with `cmd_stop` high raises `stop_pulse` for exactly one cycle, the cycle after its end bit is shifted. Other commands never raise it.
- R9: The four flags are sticky. A cycle with `flag_clr_wr` high clears exactly the bits set in `flag_clr_mask`.
- R10: The frame and the response advance only on cycles with `card_tick` high. Without ticks, `line_out` holds its value.
- R11: After reset, `busy`, `line_oe`, `stop_pulse`, the flags and the response words are 0, and `line_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_tick | input | 1 | One-cycle enable per card-clock period |
| arg_wr | input | 1 | Load the argument register |
| arg_wdata | input | 32 | Command argument |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_index | input | 6 | Command index |
| cmd_resp_mode | input | 2 | Response mode: 0 none, 1 short+CRC, 2 short raw, 3 long |
| cmd_stop | input | 1 | Marks a stop-transmission command |
| cmd_start | input | 1 | Start bit of the command write |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 4 | Flags to clear (1 = clear) |
| line_in | input | 1 | Command line as seen from the card |
| line_out | output | 1 | Command line value driven to the card |
| line_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | Command in progress |
| flags | output | 4 | Sticky flags: 0 sent, 1 response, 2 CRC fail, 3 timeout |
| stop_pulse | output | 1 | One-cycle abort request after a stop command |
| resp_data | output | 128 | Response words 1..4, word 1 in the top 32 bits |

## Verification
The bound checker checks on every cycle the properties that hold at any moment:
- the line is driven only while busy, is idle high otherwise, and opens each frame with a 0;
- it holds its level across missing ticks;
- busy rises only after a start write;
- flags never drop without a clear, and at most one outcome flag appears per cycle;
- the stop pulse lasts a single cycle.

Only the bench scenarios can show the values themselves: the exact frame bits and CRC for every index, the 63/64 boundary of the response window, the CRC verdict per mode, and which response words a short or long reply overwrites.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IDX_W = 6;
  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'b0001001;

  localparam int FLG_SENT = 0;
  localparam int FLG_RESP = 1;
  localparam int FLG_CRC  = 2;
  localparam int FLG_TMO  = 3;
  localparam int FLG_N    = 4;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'b00,
    RSP_SHORT_CRC = 2'b01,
    RSP_SHORT_RAW = 2'b10,
    RSP_LONG      = 2'b11
  } rsp_mode_e;

  typedef enum logic [1:0] {CP_IDLE, CP_SEND, CP_RESP} cp_state_e;
  typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_SHIFT, RX_CHECK} rx_state_e;

  // one serial CRC7 step, MSB-first input bit
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               line_out,
  output logic               line_oe,
  output logic               last_bit
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   left;

  assign last_bit = line_oe && tick && (left == CNT_W'(1));
  assign line_out = line_oe ? sreg[FRAME_W-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      left    <= '0;
      line_oe <= 1'b0;
    end else if (load && !line_oe) begin
      sreg    <= frame;
      left    <= CNT_W'(FRAME_W);
      line_oe <= 1'b1;
    end else if (line_oe && tick) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b1};
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) line_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx
  import sdc_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int LONG_WORDS    = 4,
  parameter int SHORT_W       = 48,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         arm,
  input  logic                         long_mode,
  input  logic                         line_in,
  output logic                         done,
  output logic                         timeout,
  output logic                         crc_ok,
  output logic [WORD_W*LONG_WORDS-1:0] body
);
  localparam int LONG_BODY = WORD_W * LONG_WORDS;
  localparam int LONG_W    = LONG_BODY + 8;
  localparam int CNT_W     = $clog2(LONG_W + 1);
  localparam int TMR_W     = $clog2(TIMEOUT_TICKS + 1);

  rx_state_e          state;
  logic               long_q;
  logic [CNT_W-1:0]   left;
  logic [TMR_W-1:0]   tmr;
  logic [LONG_BODY-1:0] sreg;
  logic [CRC_W-1:0]   crc;
  logic               crc_en;
  int                 bit_idx;
  int                 crc_top;

  always_comb begin
    bit_idx = int'(left) - 1;
    crc_top = long_q ? LONG_BODY - 1 : SHORT_W - 2;
    crc_en  = (state == RX_SHIFT) && tick && (bit_idx >= CRC_W + 1) && (bit_idx <= crc_top);
  end

  sdc_crc7 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (arm),
    .en  (crc_en),
    .din (line_in),
    .crc (crc)
  );

  assign done   = (state == RX_CHECK);
  assign crc_ok = (crc == sreg[CRC_W:1]);
  assign body   = sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_OFF;
      long_q  <= 1'b0;
      left    <= '0;
      tmr     <= '0;
      sreg    <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      case (state)
        RX_OFF: if (arm) begin
          state  <= RX_HUNT;
          long_q <= long_mode;
          tmr    <= '0;
        end
        RX_HUNT: if (tick) begin
          if (!line_in) begin
            state <= RX_SHIFT;
            left  <= long_q ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);
          end else if (tmr == TMR_W'(TIMEOUT_TICKS - 1)) begin
            state   <= RX_OFF;
            timeout <= 1'b1;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        RX_SHIFT: if (tick) begin
          sreg <= {sreg[LONG_BODY-2:0], line_in};
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) state <= RX_CHECK;
        end
        default: state <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_path.sv
module sdc_cmd_path
  import sdc_pkg::*;
#(
  parameter int ARG_W         = 32,
  parameter int WORD_W        = 32,
  parameter int LONG_WORDS    = 4,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         card_tick,
  input  logic                         arg_wr,
  input  logic [ARG_W-1:0]             arg_wdata,
  input  logic                         cmd_wr,
  input  logic [IDX_W-1:0]             cmd_index,
  input  logic [1:0]                   cmd_resp_mode,
  input  logic                         cmd_stop,
  input  logic                         cmd_start,
  input  logic                         flag_clr_wr,
  input  logic [FLG_N-1:0]             flag_clr_mask,
  input  logic                         line_in,
  output logic                         line_out,
  output logic                         line_oe,
  output logic                         busy,
  output logic [FLG_N-1:0]             flags,
  output logic                         stop_pulse,
  output logic [WORD_W*LONG_WORDS-1:0] resp_data
);
  localparam int HEAD_W    = 2 + IDX_W + ARG_W;
  localparam int FRAME_W   = HEAD_W + CRC_W + 1;
  localparam int LONG_BODY = WORD_W * LONG_WORDS;

  cp_state_e            state;
  rsp_mode_e            mode_q;
  logic                 stop_q;
  logic [ARG_W-1:0]     arg_q;
  logic [HEAD_W-1:0]    head;
  logic [CRC_W-1:0]     tx_crc;
  logic [FRAME_W-1:0]   frame;
  logic                 accept;
  logic                 tx_last;
  logic                 rx_arm;
  logic                 rx_done;
  logic                 rx_tmo;
  logic                 rx_crc_ok;
  logic [LONG_BODY-1:0] rx_body;
  logic [FLG_N-1:0]     flag_set;
  logic [FLG_N-1:0]     flag_clr;

  assign accept = cmd_wr && cmd_start && (state == CP_IDLE);
  assign busy   = (state != CP_IDLE);
  assign rx_arm = tx_last && (mode_q != RSP_NONE);

  always_comb begin
    head   = {1'b0, 1'b1, cmd_index, arg_q};
    tx_crc = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) tx_crc = crc7_step(tx_crc, head[i]);
    frame  = {head, tx_crc, 1'b1};
  end

  sdc_cmd_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tick     (card_tick),
    .load     (accept),
    .frame    (frame),
    .line_out (line_out),
    .line_oe  (line_oe),
    .last_bit (tx_last)
  );

  sdc_resp_rx #(
    .WORD_W        (WORD_W),
    .LONG_WORDS    (LONG_WORDS),
    .SHORT_W       (FRAME_W),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (card_tick),
    .arm       (rx_arm),
    .long_mode (mode_q == RSP_LONG),
    .line_in   (line_in),
    .done      (rx_done),
    .timeout   (rx_tmo),
    .crc_ok    (rx_crc_ok),
    .body      (rx_body)
  );

  always_comb begin
    flag_set = '0;
    if (tx_last && mode_q == RSP_NONE) flag_set[FLG_SENT] = 1'b1;
    if (rx_done) begin
      if ((mode_q == RSP_SHORT_CRC || mode_q == RSP_LONG) && !rx_crc_ok)
        flag_set[FLG_CRC] = 1'b1;
      else
        flag_set[FLG_RESP] = 1'b1;
    end
    if (rx_tmo) flag_set[FLG_TMO] = 1'b1;
    flag_clr = flag_clr_wr ? flag_clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CP_IDLE;
      mode_q     <= RSP_NONE;
      stop_q     <= 1'b0;
      arg_q      <= '0;
      flags      <= '0;
      stop_pulse <= 1'b0;
    end else begin
      if (arg_wr) arg_q <= arg_wdata;
      stop_pulse <= tx_last && stop_q;
      flags      <= (flags & ~flag_clr) | flag_set;
      case (state)
        CP_IDLE: if (accept) begin
          state  <= CP_SEND;
          mode_q <= rsp_mode_e'(cmd_resp_mode);
          stop_q <= cmd_stop;
        end
        CP_SEND: if (tx_last) state <= (mode_q == RSP_NONE) ? CP_IDLE : CP_RESP;
        CP_RESP: if (rx_done || rx_tmo) state <= CP_IDLE;
        default: state <= CP_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LONG_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (rx_done) begin
        if (mode_q == RSP_LONG)
          word_q <= rx_body[LONG_BODY-1-g*WORD_W -: WORD_W];
        else if (g == 0)
          word_q <= rx_body[CRC_W+WORD_W:CRC_W+1];
      end
    end
    assign resp_data[LONG_BODY-1-g*WORD_W -: WORD_W] = word_q;
  end
endmodule

// File: rtl/sdc_cmd_path_chk.sv
module sdc_cmd_path_chk (
  input logic       clk,
  input logic       rst,
  input logic       card_tick,
  input logic       cmd_wr,
  input logic       cmd_start,
  input logic       flag_clr_wr,
  input logic       line_out,
  input logic       line_oe,
  input logic       busy,
  input logic [3:0] flags,
  input logic       stop_pulse
);
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> line_out);

  assert_frame_opens_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe) |-> !line_out);

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_wr && cmd_start));

  assert_drive_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(flags & ~$past(flags)) <= 1);

  assert_stop_single_R8: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(flag_clr_wr) |-> ((flags & $past(flags)) == $past(flags)));

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (line_oe && $past(line_oe) && !$past(card_tick)) |-> $stable(line_out));
endmodule

bind sdc_cmd_path sdc_cmd_path_chk u_chk (.*);

// File: tb/tb_sdc_cmd_path.sv
module tb_sdc_cmd_path;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         card_tick = 1'b1;
  logic         arg_wr = 1'b0;
  logic [31:0]  arg_wdata = '0;
  logic         cmd_wr = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [1:0]   cmd_resp_mode = '0;
  logic         cmd_stop = 1'b0;
  logic         cmd_start = 1'b0;
  logic         flag_clr_wr = 1'b0;
  logic [3:0]   flag_clr_mask = '0;
  logic         line_in = 1'b1;
  logic         line_out, line_oe, busy, stop_pulse;
  logic [3:0]   flags;
  logic [127:0] resp_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] ew [4];

  always #(PERIOD/2) clk = ~clk;

  sdc_cmd_path dut (
    .clk(clk), .rst(rst), .card_tick(card_tick),
    .arg_wr(arg_wr), .arg_wdata(arg_wdata),
    .cmd_wr(cmd_wr), .cmd_index(cmd_index), .cmd_resp_mode(cmd_resp_mode),
    .cmd_stop(cmd_stop), .cmd_start(cmd_start),
    .flag_clr_wr(flag_clr_wr), .flag_clr_mask(flag_clr_mask),
    .line_in(line_in), .line_out(line_out), .line_oe(line_oe),
    .busy(busy), .flags(flags), .stop_pulse(stop_pulse), .resp_data(resp_data)
  );

  function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] a);
    logic [39:0] h;
    h = {2'b01, idx, a};
    return {h, ref_crc({88'd0, h}, 40), 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] idx, input logic [1:0] mode, input logic stp, input logic [31:0] a);
    @(negedge clk);
    arg_wr = 1'b1; arg_wdata = a;
    @(negedge clk);
    arg_wr = 1'b0;
    cmd_wr = 1'b1; cmd_index = idx; cmd_resp_mode = mode; cmd_stop = stp; cmd_start = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
  endtask

  // called at a negedge; returns at the negedge where the last bit was seen
  task automatic capture(output logic [47:0] f);
    int cnt = 0;
    int guard = 0;
    f = '0;
    while (cnt < 48 && guard < 4000) begin
      if (line_oe && card_tick) begin
        f = {f[46:0], line_out};
        cnt++;
      end
      if (cnt < 48) begin
        @(negedge clk);
        guard++;
      end
    end
  endtask

  task automatic clear_flags(input logic [3:0] m);
    @(negedge clk);
    flag_clr_wr = 1'b1; flag_clr_mask = m;
    @(negedge clk);
    flag_clr_wr = 1'b0; flag_clr_mask = '0;
  endtask

  task automatic resp_case(input logic [5:0] idx, input logic [1:0] mode, input bit bad,
                           input int gap, input logic [119:0] content, input logic [31:0] pay);
    logic [47:0]  f;
    logic [135:0] rb;
    logic [6:0]   c;
    int           len;
    logic [3:0]   ef;
    logic [31:0]  a;
    a = {content[31:0]} ^ 32'h5A5A_0F0F;
    issue(idx, mode, 1'b0, a);
    capture(f);
    check(f == ref_frame(idx, a), "R1 frame before response", {80'd0, f}, {80'd0, ref_frame(idx, a)});
    rb = '0;
    if (mode == 2'd3) begin
      c = ref_crc({8'd0, content}, 120);
      if (bad) c = c ^ 7'h01;
      rb = {2'b00, 6'h3F, content, c, 1'b1};
      len = 136;
    end else begin
      c = ref_crc({88'd0, 2'b00, idx, pay}, 40);
      if (bad) c = c ^ 7'h01;
      rb[47:0] = {2'b00, idx, pay, c, 1'b1};
      len = 48;
    end
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      line_in = 1'b1;
    end
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      line_in = rb[i];
    end
    @(negedge clk);
    line_in = 1'b1;
    repeat (2) @(negedge clk);
    ef = (mode == 2'd2 || !bad) ? 4'b0010 : 4'b0100;
    if (mode == 2'd3) begin
      ew[0] = rb[127:96]; ew[1] = rb[95:64]; ew[2] = rb[63:32]; ew[3] = rb[31:0];
    end else begin
      ew[0] = pay;
    end
    check(flags == ef, "R6 outcome flag", {124'd0, flags}, {124'd0, ef});
    check(resp_data == {ew[0], ew[1], ew[2], ew[3]}, "R7 response words",
          resp_data, {ew[0], ew[1], ew[2], ew[3]});
    check(!busy, "R3 idle after response", {127'd0, busy}, 128'd0);
    clear_flags(4'hF);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] f;
    logic [31:0] a;
    for (int i = 0; i < 4; i++) ew[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !line_oe && !stop_pulse, "R11 control outputs", {125'd0, busy, line_oe, stop_pulse}, 128'd0);
    check(line_out == 1'b1, "R11 idle line", {127'd0, line_out}, 128'd1);
    check(flags == 4'd0 && resp_data == '0, "R11 flags and words", {flags, resp_data[123:0]}, 128'd0);

    // R1 + R4 sweep over every command index
    for (int idx = 0; idx < 64; idx++) begin
      a = 32'h9E37_79B9 * (idx + 1);
      issue(6'(idx), 2'd0, 1'b0, a);
      capture(f);
      check(f == ref_frame(6'(idx), a), "R1 frame bits", {80'd0, f}, {80'd0, ref_frame(6'(idx), a)});
      @(negedge clk);
      check(flags == 4'b0001, "R4 sent flag", {124'd0, flags}, 128'd1);
      check(!stop_pulse && !busy, "R8 no stop pulse / R4 no listening", {126'd0, stop_pulse, busy}, 128'd0);
      clear_flags(4'hF);
    end

    // R9 sticky flag, selective clear
    issue(6'd7, 2'd0, 1'b0, 32'h1234_5678);
    capture(f);
    repeat (2) @(negedge clk);
    clear_flags(4'b1110);
    check(flags == 4'b0001, "R9 flag kept under other mask", {124'd0, flags}, 128'd1);
    repeat (5) @(negedge clk);
    check(flags == 4'b0001, "R9 flag held without clear", {124'd0, flags}, 128'd1);
    clear_flags(4'b0001);
    check(flags == 4'b0000, "R9 flag cleared", {124'd0, flags}, 128'd0);

    // R2 write without start bit
    @(negedge clk);
    cmd_wr = 1'b1; cmd_index = 6'd3; cmd_start = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (10) @(negedge clk);
    check(!busy && !line_oe && line_out, "R2 no start without start bit", {125'd0, busy, line_oe, line_out}, 128'd1);

    // R3 write while busy is ignored
    a = 32'hCAFE_F00D;
    issue(6'd5, 2'd0, 1'b0, a);
    fork
      capture(f);
      begin
        repeat (5) @(negedge clk);
        check(busy, "R3 busy during frame", {127'd0, busy}, 128'd1);
        cmd_wr = 1'b1; cmd_index = 6'd9; cmd_resp_mode = 2'd3; cmd_start = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_start = 1'b0;
      end
    join
    check(f == ref_frame(6'd5, a), "R3 frame unchanged by busy write", {80'd0, f}, {80'd0, ref_frame(6'd5, a)});
    repeat (12) @(negedge clk);
    check(!busy && !line_oe, "R3 no second command", {126'd0, busy, line_oe}, 128'd0);
    check(flags == 4'b0001, "R3 first command outcome kept", {124'd0, flags}, 128'd1);
    clear_flags(4'hF);

    // R10 no progress without ticks
    card_tick = 1'b0;
    a = 32'h0BAD_BEEF;
    issue(6'd17, 2'd0, 1'b0, a);
    repeat (10) @(negedge clk);
    check(line_oe && busy && !line_out, "R10 start bit held", {125'd0, line_oe, busy, line_out}, 128'd6);
    card_tick = 1'b1;
    capture(f);
    check(f == ref_frame(6'd17, a), "R10 frame after ticks resume", {80'd0, f}, {80'd0, ref_frame(6'd17, a)});
    repeat (2) @(negedge clk);
    clear_flags(4'hF);

    // R8 stop command
    issue(6'd12, 2'd0, 1'b1, 32'h0);
    capture(f);
    @(negedge clk);
    check(stop_pulse, "R8 stop pulse raised", {127'd0, stop_pulse}, 128'd1);
    @(negedge clk);
    check(!stop_pulse, "R8 stop pulse one cycle", {127'd0, stop_pulse}, 128'd0);
    clear_flags(4'hF);

    // R5 R6 R7 responses across modes and CRC outcomes
    for (int m = 1; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        for (int p = 0; p < 3; p++) begin
          resp_case(6'(m * 8 + b * 4 + p), 2'(m), bit'(b), p * 5,
                    {120{1'b0}} ^ ({4{32'h3C5A_9671 * (m * 7 + b * 3 + p + 1)}} >> 8),
                    32'h8765_4321 ^ (32'h0101_0101 * (m * 6 + b * 3 + p)));
        end
      end
    end

    // R5 window boundary: start bit on the 64th sample is accepted
    resp_case(6'd40, 2'd1, 1'b0, 63, 120'h0123_4567_89AB_CDEF_0011_2233_4455_66, 32'hFEED_0001);

    // R5 no start bit within 64 samples gives timeout
    issue(6'd41, 2'd1, 1'b0, 32'h7);
    capture(f);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      line_in = 1'b1;
    end
    check(busy && flags == 4'd0, "R5 still listening at 64th sample", {123'd0, busy, flags}, 128'h10);
    repeat (2) @(negedge clk);
    check(flags == 4'b1000, "R5 timeout flag", {124'd0, flags}, 128'h8);
    check(!busy, "R5 idle after timeout", {127'd0, busy}, 128'd0);
    check(resp_data == {ew[0], ew[1], ew[2], ew[3]}, "R7 words untouched by timeout",
          resp_data, {ew[0], ew[1], ew[2], ew[3]});
    clear_flags(4'b1000);
    check(flags == 4'd0, "R9 timeout cleared", {124'd0, flags}, 128'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule